// File: doc/BRIEF.md
# Multiplexed Monitor Word Scanner

This block gathers sixteen 16-bit status words from remote logic over one shared 16-bit input. It drives a 4-bit select code to an external multiplexer. It advances that code on a fixed period and wraps back to zero after the last word. A set settling time after each change of the code, it captures the presented word into a local cache entry. A host command decoder reads any cached word at any time through a combinational read port.

A liveness watchdog produces an update-active flag. The flag drops when no capture has happened for two full scan rounds, for example while the scan-enable input is held low. An attention output is raised whenever the flag is low. Two build options can also raise it when the low or high byte of cached word 0 is not all ones. Each byte has its own enable. All timing comes from a clock rate in MHz and step and settle times in microseconds, given as parameters.

Top module: `mon_scan_top`

## Requirements
- R1: During and after reset, the select code is 0, every cache entry reads 0 and update-active is 1. At that point attention reflects only the enabled byte checks.
- R2: While scan-enable is 1, the select code advances by one every STEP_US*CLK_MHZ cycles and goes from 15 to 0.
- R3: The entry indexed by the current select code takes the input word at the end of the SETTLE_US*CLK_MHZ-th enabled cycle after the code changed. The new value can be read from the following cycle onward.
- R4: With scan-enable held at 1 and steady inputs, every one of the 16 entries holds its presented word after one round of 16 steps.
- R5: While scan-enable is 0, the select code, the step timing and all cache entries stay unchanged.
- R6: update-active goes to 0 once 32 step periods have passed with no capture. It returns to 1 in the cycle after the next capture.
- R7: attention is 1 whenever update-active is 0.
- R8: With CHK_LO=1, attention is 1 while bits 7:0 of cached word 0 are not all ones. With CHK_HI=1, the same applies to bits 15:8. A disabled byte check has no effect.
- R9: The read port is combinational on its 4-bit address. In the cycle when a capture targets the addressed entry, it still returns the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Enables stepping and capture |
| mon_in | input | 16 | Word presented by the external multiplexer |
| mux_addr | output | 4 | Select code to the external multiplexer |
| rd_addr | input | 4 | Cache read index |
| rd_data | output | 16 | Cached word at rd_addr |
| update_active | output | 1 | Scanning liveness flag |
| attn_req | output | 1 | Attention request |

## Verification
A capture into an entry and a host read of that same entry can fall in the same cycle. The bench provokes this by steering the read index to follow the select code for several rounds while the presented words keep changing. It judges the result against a behavioural model: in the capture cycle the old word must be returned, and from the next cycle the new one. A second overlap is the watchdog expiry meeting the capture that follows re-enable. Update-active must come back exactly one cycle after that capture.

// File: rtl/mon_scan_pkg.sv
package mon_scan_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 4;
  typedef logic [WORD_W-1:0] mon_word_t;
  typedef logic [ADDR_W-1:0] mon_idx_t;

  function automatic mon_idx_t next_idx(input mon_idx_t cur);
    return mon_idx_t'(cur + 1'b1);
  endfunction

  function automatic logic byte_short(input logic [7:0] b);
    return (b != 8'hFF);
  endfunction
endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int unsigned STEP_CYC   = 2500,
  parameter int unsigned SETTLE_CYC = 2000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  output mon_scan_pkg::mon_idx_t sel,
  output logic                  cap_evt,
  output logic                  step_evt
);
  import mon_scan_pkg::*;
  localparam int unsigned CW = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] LAST_C   = CW'(STEP_CYC - 1);
  localparam logic [CW-1:0] SETTLE_C = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  mon_idx_t      sel_q;

  assign step_evt = en && (cnt_q == LAST_C);
  assign cap_evt  = en && (cnt_q == SETTLE_C);
  assign sel      = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (en) begin
      if (step_evt) begin
        cnt_q <= '0;
        sel_q <= next_idx(sel_q);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sel_q));
  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (sel_q == next_idx($past(sel_q))));
  // R3
  no_double_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_evt && step_evt));
endmodule

// File: rtl/mon_cache.sv
module mon_cache (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  mon_scan_pkg::mon_idx_t  wr_idx,
  input  mon_scan_pkg::mon_word_t wr_data,
  input  mon_scan_pkg::mon_idx_t  rd_idx,
  output mon_scan_pkg::mon_word_t rd_data,
  output mon_scan_pkg::mon_word_t word0
);
  import mon_scan_pkg::*;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  mon_word_t ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else if (wr_en && (wr_idx == mon_idx_t'(g))) ent_q[g] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_idx];
  assign word0   = ent_q[0];

  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) ##1 (rd_idx == $past(rd_idx)) |-> rd_data == $past(wr_data));
endmodule

// File: rtl/live_watch.sv
module live_watch #(
  parameter int unsigned LIMIT  = 80000,
  parameter bit          CHK_LO = 1'b0,
  parameter bit          CHK_HI = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_evt,
  input  mon_scan_pkg::mon_word_t word0,
  output logic                   alive,
  output logic                   attn
);
  import mon_scan_pkg::*;
  localparam int unsigned WW = $clog2(LIMIT + 1);
  localparam logic [WW-1:0] LIM_C = WW'(LIMIT);

  logic [WW-1:0] idle_q;
  logic lo_bad, hi_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idle_q <= '0;
    else if (cap_evt)        idle_q <= '0;
    else if (idle_q != LIM_C) idle_q <= idle_q + 1'b1;
  end

  assign alive = (idle_q != LIM_C);

  if (CHK_LO) begin : g_lo
    assign lo_bad = byte_short(word0[7:0]);
  end else begin : g_lo_off
    assign lo_bad = 1'b0;
  end
  if (CHK_HI) begin : g_hi
    assign hi_bad = byte_short(word0[15:8]);
  end else begin : g_hi_off
    assign hi_bad = 1'b0;
  end

  assign attn = !alive || lo_bad || hi_bad;

  // R6
  revive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> alive);
  // R7
  dead_attn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alive |-> attn);
  // R6
  stay_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alive && !cap_evt) |=> !alive);
endmodule

// File: rtl/mon_scan_top.sv
module mon_scan_top #(
  parameter int unsigned CLK_MHZ   = 250,
  parameter int unsigned STEP_US   = 10,
  parameter int unsigned SETTLE_US = 8,
  parameter bit          CHK_LO    = 1'b0,
  parameter bit          CHK_HI    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_en,
  input  logic [15:0] mon_in,
  output logic [3:0]  mux_addr,
  input  logic [3:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        update_active,
  output logic        attn_req
);
  import mon_scan_pkg::*;
  localparam int unsigned STEP_CYC   = CLK_MHZ * STEP_US;
  localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int unsigned ROUND_CYC  = STEP_CYC * (1 << ADDR_W);
  localparam int unsigned WD_LIMIT   = 2 * ROUND_CYC;

  logic      cap_evt, step_evt;
  mon_idx_t  sel;
  mon_word_t word0;

  scan_timer #(.STEP_CYC(STEP_CYC), .SETTLE_CYC(SETTLE_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .en(scan_en),
    .sel(sel), .cap_evt(cap_evt), .step_evt(step_evt));

  mon_cache cache_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_evt), .wr_idx(sel),
    .wr_data(mon_in), .rd_idx(rd_addr), .rd_data(rd_data), .word0(word0));

  live_watch #(.LIMIT(WD_LIMIT), .CHK_LO(CHK_LO), .CHK_HI(CHK_HI)) watch_i (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .word0(word0),
    .alive(update_active), .attn(attn_req));

  assign mux_addr = sel;

  // R5
  cap_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || step_evt) |-> scan_en);
  // R2
  addr_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(mux_addr));
endmodule

// File: tb/mon_scan_top_tb_top.sv
module mon_scan_top_tb_top;
  localparam int MHZ = 2, STEP = 20, SETTLE = 16, LIMIT = 32 * STEP;

  logic clk = 0, rst_n = 0, scan_en = 0;
  logic [15:0] mon_in, rd_data;
  logic [3:0] mux_addr, rd_addr = 0;
  logic update_active, attn_req;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] pat [16];
  string ph = "R3";
  bit follow = 0;

  // reference model state
  int m_cnt, m_addr, m_wd;
  logic [15:0] m_cache [16];

  always #2 clk = ~clk;

  assign mon_in = pat[mux_addr];

  mon_scan_top #(.CLK_MHZ(MHZ), .STEP_US(10), .SETTLE_US(8), .CHK_LO(1'b1), .CHK_HI(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mon_in(mon_in), .mux_addr(mux_addr),
    .rd_addr(rd_addr), .rd_data(rd_data), .update_active(update_active), .attn_req(attn_req));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = 0; m_addr = 0; m_wd = 0;
      for (int i = 0; i < 16; i++) m_cache[i] = 16'h0;
    end else if (scan_en) begin
      if (m_cnt == SETTLE - 1) begin
        m_cache[m_addr] = pat[m_addr];
        m_wd = 0;
      end else if (m_wd != LIMIT) m_wd++;
      if (m_cnt == STEP - 1) begin m_cnt = 0; m_addr = (m_addr + 1) % 16; end
      else m_cnt++;
    end else if (m_wd != LIMIT) m_wd++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    automatic bit act = (m_wd != LIMIT);
    automatic bit lo  = (m_cache[0][7:0] != 8'hFF);
    chk(scan_en ? "R2" : "R5", mux_addr, m_addr);
    chk(ph, rd_data, m_cache[rd_addr]);
    chk("R6", update_active, act);
    chk(act ? "R8" : "R7", attn_req, !act || lo);
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rd_addr = follow ? 4'(m_addr) : 4'(i * 7);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) pat[i] = 16'h3000 + 16'(i * 16'h0513);
    pat[0] = 16'h00FF;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", mux_addr, 0);
    chk("R1", update_active, 1);
    chk("R1", attn_req, 1);  // low byte of word 0 is zero and CHK_LO is on
    for (int i = 0; i < 16; i++) begin rd_addr = 4'(i); #0.1; chk("R1", rd_data, 0); end
    rst_n = 1; scan_en = 1;
    ph = "R3"; run(2 * 16 * STEP + 10);
    // R4: full round landed every word
    @(negedge clk); #1;
    for (int i = 0; i < 16; i++) begin rd_addr = 4'(i); #0.1; chk("R4", rd_data, pat[i]); end
    ph = "R8"; pat[0] = 16'hFF00; run(16 * STEP + 5);
    pat[0] = 16'h12FF; run(16 * STEP + 5);
    ph = "R5"; scan_en = 0;
    for (int i = 0; i < 16; i++) pat[i] = ~pat[i];
    run(LIMIT + 40);
    chk("R7", attn_req, 1);
    ph = "R6"; scan_en = 1; run(16 * STEP + 10);
    ph = "R9"; follow = 1;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 16; i++) pat[i] = pat[i] + 16'(k * 16'h0101 + 1);
      pat[0][7:0] = 8'hFF;
      run(16 * STEP);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule